// File: doc/BRIEF.md
# Maskable Interrupt Request Controller

This block gathers maskable interrupt requests for a small microcontroller core. Every source owns an 8-bit control register. The register holds a 3-bit priority level and a pending-request flag. Sources tied to external pins also have an edge-select bit. Internal peripherals raise a one-cycle event pulse. External pins pass through a two-flop synchronizer and an edge detector whose active edge is selectable. The control registers sit on a plain byte bus with a write strobe and a combinational read path.

On every cycle the block finds the highest-level pending source that is enabled. Level 0 means disabled. If two or more sources share the top level, the lowest index wins. The block raises its interrupt output only when the global enable is set and the winner's level is strictly above the processor priority level. The core returns the winning index on an acknowledge port, and that source's flag is then cleared.

Source `i` sits at bus address `i`. Internal sources take indices `0 .. N_INT-1`. External pin sources follow at `N_INT .. N_INT+N_EXT-1`.

Top module: `irq_req_ctrl`

## Requirements
- R1: After reset every control register reads 0x00. Bits 2..0 hold a level from 0 to 7, and a write stores them where a read returns them.
- R2: A source whose level is 0 is never granted, even while its request flag (bit 3) reads 1.
- R3: Bit 3 is the request flag (1 = pending). Writing 0 to it clears it. Writing 1 to it leaves it unchanged.
- R4: On internal sources, bits 7..4 always read 0 and writes to them have no effect. An event pulse sets the flag at the next clock edge.
- R5: On external sources, bit 4 selects the edge: 1 = rising, 0 = falling. Bits 7..5 always read 0. An edge of the unselected direction does not set the flag.
- R6: A change on an external pin sets its flag at the third rising clock edge after the change. Before that edge the flag still reads 0.
- R7: `irq` is 1 only when `gie` is 1 and the winning level is strictly greater than `cpu_ipl`.
- R8: The winner is the pending source with the highest nonzero level. Among equal levels the lowest index wins. Its index is driven on `irq_idx` and its level on `irq_lvl`.
- R9: A hardware request wins over a software clear or an acknowledge of the same source in the same cycle, so the flag ends up set.
- R10: An acknowledge with index `k` clears source `k`'s flag at the next clock edge.
- R11: Addresses at or above `N_INT+N_EXT` read 0x00, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Register address (source index) |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe |
| rdata | output | 8 | Combinational read data |
| int_evt | input | N_INT | One-cycle request pulses from internal sources |
| ext_pin | input | N_EXT | Asynchronous external request pins |
| gie | input | 1 | Global maskable-interrupt enable |
| cpu_ipl | input | 3 | Current processor priority level |
| ack | input | 1 | Acknowledge strobe |
| ack_idx | input | IDX_W | Index of the acknowledged source |
| irq | output | 1 | Interrupt request to the core |
| irq_idx | output | IDX_W | Index of the winning source |
| irq_lvl | output | 3 | Level of the winning source |

## Verification
Some properties are checked on every cycle:
- `irq` never rises without `gie` set and a winning level strictly above `cpu_ipl`.
- The reported winner is actually pending and carries the reported level, and that level is never 0.
- No request flag rises without a hardware event in the prior cycle, so software cannot set a flag.
- An acknowledge clears its flag unless a hardware event collides with it.
- Unused read bits and unmapped addresses return 0.

Other behaviour only the bench scenarios show:
- The three-edge latency of the pin synchronizer.
- Rejection of the unselected edge direction.
- Lowest-index tie-breaking.
- Precedence of a simultaneous hardware set over a software clear.

// File: rtl/irq_pkg.sv
// Package: shared types and field positions for the interrupt request controller.
// Assumes byte-wide control registers with the level in bits 2..0.
package irq_pkg;
    typedef logic [2:0] lvl_t;

    localparam int LVL_W   = 3;
    localparam int REQ_BIT = 3;
    localparam int POL_BIT = 4;
endpackage

// File: rtl/irq_edge_sync.sv
// Module: brings one asynchronous pin into the clock domain with two flops,
// then emits a one-cycle pulse on the edge that the polarity input selects.
// Assumes the pin is low during reset (flops clear to 0).
module irq_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    output logic edge_o
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Purpose: two-stage synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Purpose: pick the rising or falling transition according to pol.
    always_comb begin
        if (pol) edge_o = sync_q & ~prev_q;
        else     edge_o = ~sync_q & prev_q;
    end
endmodule

// File: rtl/irq_ctl_reg.sv
// Module: one source's control register.
// It holds the level, the request flag and, on external sources, the edge
// select. A hardware set beats a software clear or an acknowledge in the same
// cycle. Assumes wdata carries only bits 4..0 of the bus write.
module irq_ctl_reg
    import irq_pkg::*;
#(
    parameter bit IS_EXT = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_wr,
    input  logic [4:0] wdata,
    input  logic       hw_set,
    input  logic       ack_hit,
    output lvl_t       lvl_o,
    output logic       req_o,
    output logic       pol_o,
    output logic [7:0] rd_val
);
    lvl_t lvl_q;
    logic req_q;

    // Purpose: level field storage, written from bus bits 2..0.
    always_ff @(posedge clk) begin
        if (!rst_n)      lvl_q <= '0;
        else if (sel_wr) lvl_q <= wdata[LVL_W-1:0];
    end

    // Purpose: request flag; set by hardware, cleared by a 0 write or an ack.
    always_ff @(posedge clk) begin
        if (!rst_n)                               req_q <= 1'b0;
        else if (hw_set)                          req_q <= 1'b1;
        else if (ack_hit)                         req_q <= 1'b0;
        else if (sel_wr && !wdata[REQ_BIT])       req_q <= 1'b0;
    end

    generate
        if (IS_EXT) begin : g_ext
            logic pol_q;

            // Purpose: edge-select bit storage (1 = rising).
            always_ff @(posedge clk) begin
                if (!rst_n)      pol_q <= 1'b0;
                else if (sel_wr) pol_q <= wdata[POL_BIT];
            end

            assign pol_o  = pol_q;
            assign rd_val = {3'b000, pol_q, req_q, lvl_q};
        end else begin : g_int
            logic unused_pol;
            assign unused_pol = wdata[POL_BIT];
            assign pol_o      = 1'b0;
            assign rd_val     = {4'b0000, req_q, lvl_q};
        end
    endgenerate

    assign lvl_o = lvl_q;
    assign req_o = req_q;
endmodule

// File: rtl/irq_arbiter.sv
// Module: combinational priority pick over all sources.
// The highest nonzero level among pending sources wins, and ties go to the
// lowest index. The result is index 0 and level 0 when nothing is eligible.
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int IDX_W = 3
) (
    input  logic [N_SRC-1:0] req_vec,
    input  lvl_t             lvl_vec [N_SRC],
    output logic [IDX_W-1:0] win_idx,
    output lvl_t             win_lvl
);
    // Purpose: linear scan; strict compare keeps the lowest index on ties.
    always_comb begin
        win_idx = '0;
        win_lvl = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req_vec[i] && (lvl_vec[i] > win_lvl)) begin
                win_idx = IDX_W'(i);
                win_lvl = lvl_vec[i];
            end
        end
    end
endmodule

// File: rtl/irq_req_ctrl.sv
// Module: top of the maskable interrupt request controller.
// It builds N_INT internal and N_EXT external control registers, a pin edge
// detector per external source, the priority pick and the final gate against
// gie and cpu_ipl. Assumes N_INT >= 1, N_EXT >= 1 and ADDR_W >= IDX_W.
module irq_req_ctrl
    import irq_pkg::*;
#(
    parameter int N_INT  = 6,
    parameter int N_EXT  = 2,
    parameter int ADDR_W = 4,
    localparam int N_SRC = N_INT + N_EXT,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              we,
    output logic [7:0]        rdata,
    input  logic [N_INT-1:0]  int_evt,
    input  logic [N_EXT-1:0]  ext_pin,
    input  logic              gie,
    input  logic [2:0]        cpu_ipl,
    input  logic              ack,
    input  logic [IDX_W-1:0]  ack_idx,
    output logic              irq,
    output logic [IDX_W-1:0]  irq_idx,
    output logic [2:0]        irq_lvl
);
    logic [N_SRC-1:0] req_vec;
    logic [N_SRC-1:0] hw_set_vec;
    logic [N_SRC-1:0] pol_vec;
    lvl_t             lvl_vec [N_SRC];
    logic [7:0]       rd_arr  [N_SRC];
    lvl_t             win_lvl;
    logic [IDX_W-1:0] win_idx;
    logic             unused_wr;

    assign unused_wr = ^wdata[7:5];

    genvar gi;
    generate
        for (gi = 0; gi < N_SRC; gi++) begin : g_src
            logic sel_wr;
            logic ack_hit;
            assign sel_wr  = we  && (addr    == ADDR_W'(gi));
            assign ack_hit = ack && (ack_idx == IDX_W'(gi));

            irq_ctl_reg #(.IS_EXT(gi >= N_INT)) u_reg (
                .clk     (clk),
                .rst_n   (rst_n),
                .sel_wr  (sel_wr),
                .wdata   (wdata[4:0]),
                .hw_set  (hw_set_vec[gi]),
                .ack_hit (ack_hit),
                .lvl_o   (lvl_vec[gi]),
                .req_o   (req_vec[gi]),
                .pol_o   (pol_vec[gi]),
                .rd_val  (rd_arr[gi])
            );

            if (gi < N_INT) begin : g_int_evt
                assign hw_set_vec[gi] = int_evt[gi];
            end else begin : g_pin
                irq_edge_sync u_edge (
                    .clk    (clk),
                    .rst_n  (rst_n),
                    .pin    (ext_pin[gi-N_INT]),
                    .pol    (pol_vec[gi]),
                    .edge_o (hw_set_vec[gi])
                );
            end
        end
    endgenerate

    // Purpose: read mux; unmapped addresses return zero.
    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < N_SRC; i++) begin
            if (addr == ADDR_W'(i)) rdata = rd_arr[i];
        end
    end

    irq_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
        .req_vec (req_vec),
        .lvl_vec (lvl_vec),
        .win_idx (win_idx),
        .win_lvl (win_lvl)
    );

    // Purpose: final gate against global enable and processor level.
    always_comb begin
        irq     = gie && (win_lvl > cpu_ipl);
        irq_idx = win_idx;
        irq_lvl = win_lvl;
    end
endmodule

// File: rtl/irq_req_ctrl_chk.sv
// Module: assertion checker bound into irq_req_ctrl.
// It sees the ports plus the request, level and hardware-set vectors.
module irq_req_ctrl_chk #(
    parameter int N_INT  = 6,
    parameter int N_SRC  = 8,
    parameter int ADDR_W = 4,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rdata,
    input logic              gie,
    input logic [2:0]        cpu_ipl,
    input logic              ack,
    input logic [IDX_W-1:0]  ack_idx,
    input logic              irq,
    input logic [IDX_W-1:0]  irq_idx,
    input logic [2:0]        irq_lvl,
    input logic [N_SRC-1:0]  req_vec,
    input logic [N_SRC-1:0]  hw_set_vec,
    input logic [2:0]        lvl_vec [N_SRC]
);
    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (gie && (irq_lvl > cpu_ipl)));

    assert_lvl0_never_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((irq_lvl != 3'd0) && (lvl_vec[irq_idx] != 3'd0)));

    assert_winner_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (req_vec[irq_idx] && (lvl_vec[irq_idx] == irq_lvl)));

    assert_no_sw_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_vec & ~$past(req_vec) & ~$past(hw_set_vec)) == '0));

    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && (int'(ack_idx) < N_SRC) && !hw_set_vec[ack_idx])
        |=> !req_vec[$past(ack_idx)]);

    assert_int_hi_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr) < N_INT) |-> (rdata[7:4] == 4'h0));

    assert_ext_hi_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr) < N_SRC) |-> (rdata[7:5] == 3'h0));

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr) >= N_SRC) |-> (rdata == 8'h00));
endmodule

bind irq_req_ctrl irq_req_ctrl_chk #(
    .N_INT  (N_INT),
    .N_SRC  (N_SRC),
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .rdata      (rdata),
    .gie        (gie),
    .cpu_ipl    (cpu_ipl),
    .ack        (ack),
    .ack_idx    (ack_idx),
    .irq        (irq),
    .irq_idx    (irq_idx),
    .irq_lvl    (irq_lvl),
    .req_vec    (req_vec),
    .hw_set_vec (hw_set_vec),
    .lvl_vec    (lvl_vec)
);

// File: tb/irq_req_ctrl_tb.sv
// Bench: a scoreboard. Driver tasks push expected items into a queue, and a
// monitor pops and compares them mid-way through the low clock phase.
module irq_req_ctrl_tb;
    localparam int N_INT  = 6;
    localparam int N_EXT  = 2;
    localparam int ADDR_W = 4;
    localparam int IDX_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic              we = 1'b0;
    logic [7:0]        rdata;
    logic [N_INT-1:0]  int_evt = '0;
    logic [N_EXT-1:0]  ext_pin = '0;
    logic              gie = 1'b0;
    logic [2:0]        cpu_ipl = '0;
    logic              ack = 1'b0;
    logic [IDX_W-1:0]  ack_idx = '0;
    logic              irq;
    logic [IDX_W-1:0]  irq_idx;
    logic [2:0]        irq_lvl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit         is_irq;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    event  sample_ev;

    always #10 clk = ~clk;

    irq_req_ctrl #(.N_INT(N_INT), .N_EXT(N_EXT), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
        .rdata(rdata), .int_evt(int_evt), .ext_pin(ext_pin), .gie(gie),
        .cpu_ipl(cpu_ipl), .ack(ack), .ack_idx(ack_idx), .irq(irq),
        .irq_idx(irq_idx), .irq_lvl(irq_lvl)
    );

    // Monitor: pop every queued expectation and compare with the outputs.
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                act = it.is_irq ? {1'b0, irq, irq_idx, irq_lvl} : rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%02h expected=%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Tasks start just after a falling edge and end just after the next one.
    task automatic wr(input int a, input logic [7:0] d);
        addr = ADDR_W'(a); wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic chk_rd(input int a, input logic [7:0] e, input string tag);
        item_t it;
        addr = ADDR_W'(a); we = 1'b0;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        #5 -> sample_ev;
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic ei, input int ix, input int lv, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {1'b0, ei, 3'(ix), 3'(lv)}; it.tag = tag;
        sb_q.push_back(it);
        #5 -> sample_ev;
        @(negedge clk);
    endtask

    task automatic pulse(input logic [N_INT-1:0] m);
        int_evt = m;
        @(negedge clk);
        int_evt = '0;
    endtask

    task automatic do_ack(input int ix);
        ack = 1'b1; ack_idx = IDX_W'(ix);
        @(negedge clk);
        ack = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every register
        for (int a = 0; a < N_INT + N_EXT; a++) chk_rd(a, 8'h00, "R1 reset");
        chk_irq(1'b0, 0, 0, "R1 no irq after reset");

        // R4 R3: upper bits and bit 3 ignored on write; R1 level stored
        wr(0, 8'hFF);
        chk_rd(0, 8'h07, "R4 R3 write ff internal");
        wr(0, 8'h03);
        chk_rd(0, 8'h03, "R1 level 3");

        // R4: event pulse sets the flag
        pulse(6'b000001);
        chk_rd(0, 8'h0B, "R4 pulse sets flag");

        // R7: gating by gie and strict level compare
        chk_irq(1'b0, 0, 3, "R7 gie low");
        gie = 1'b1; cpu_ipl = 3'd0;
        chk_irq(1'b1, 0, 3, "R7 ipl 0");
        cpu_ipl = 3'd3;
        chk_irq(1'b0, 0, 3, "R7 ipl equal");
        cpu_ipl = 3'd2;
        chk_irq(1'b1, 0, 3, "R7 ipl below");
        cpu_ipl = 3'd0;

        // R3: write 1 keeps, write 0 clears
        wr(0, 8'h0B);
        chk_rd(0, 8'h0B, "R3 write 1 keeps");
        wr(0, 8'h03);
        chk_rd(0, 8'h03, "R3 write 0 clears");

        // R2: level 0 source pending but never granted
        pulse(6'b000010);
        chk_rd(1, 8'h08, "R2 pending at level 0");
        chk_irq(1'b0, 0, 0, "R2 level 0 not granted");

        // R8: tie goes to lowest index, higher level wins
        wr(2, 8'h05); wr(3, 8'h05); wr(4, 8'h06);
        pulse(6'b001100);
        chk_irq(1'b1, 2, 5, "R8 tie lowest index");
        pulse(6'b010000);
        chk_irq(1'b1, 4, 6, "R8 higher level wins");

        // R10: acknowledge clears on next edge
        do_ack(4);
        chk_rd(4, 8'h06, "R10 ack clears");
        chk_irq(1'b1, 2, 5, "R10 next winner");
        do_ack(2); do_ack(3);
        chk_irq(1'b0, 0, 0, "R10 all cleared");

        // R5: external register layout, bit 4 rising select
        wr(6, 8'hFF);
        chk_rd(6, 8'h17, "R5 ext write ff");

        // R6: three-edge latency on a rising pin
        ext_pin[0] = 1'b1;
        @(negedge clk);
        chk_rd(6, 8'h17, "R6 not yet after 1 edge");
        chk_rd(6, 8'h17, "R6 not yet after 2 edges");
        chk_rd(6, 8'h1F, "R6 set after 3 edges");
        chk_irq(1'b1, 6, 7, "R6 R8 pin source wins");

        // R5: falling edge ignored when rising selected
        wr(6, 8'h17);
        ext_pin[0] = 1'b0;
        repeat (4) @(negedge clk);
        chk_rd(6, 8'h17, "R5 falling ignored");

        // R5: falling select on second pin
        wr(7, 8'h02);
        ext_pin[1] = 1'b1;
        repeat (4) @(negedge clk);
        chk_rd(7, 8'h02, "R5 rising ignored on falling select");
        ext_pin[1] = 1'b0;
        repeat (3) @(negedge clk);
        chk_rd(7, 8'h0A, "R5 falling sets");

        // R9: hardware set beats software clear and ack in one cycle
        wr(5, 8'h01);
        addr = 4'd5; wdata = 8'h01; we = 1'b1; int_evt = 6'b100000;
        @(negedge clk);
        we = 1'b0; int_evt = '0;
        chk_rd(5, 8'h09, "R9 set beats clear");
        ack = 1'b1; ack_idx = 3'd5; int_evt = 6'b100000;
        @(negedge clk);
        ack = 1'b0; int_evt = '0;
        chk_rd(5, 8'h09, "R9 set beats ack");

        // R11: unmapped addresses
        wr(9, 8'hFF);
        for (int a = 8; a < 16; a++) chk_rd(a, 8'h00, "R11 unmapped reads 0");
        chk_rd(1, 8'h08, "R11 write had no effect");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule